// File: doc/BRIEF.md
# Power Sequencing Timing Monitor

This block watches the active-low control lines that move a processor package between its normal and low-power states. The lines are stop-clock, sleep, deep-sleep, deep-power-stop and the system reset. The monitor also watches the acknowledge-response strobe and the "stop-grant reached" status. It counts bus clocks and checks the separations that the sequencing rules require between particular edges. It never drives any of these signals, and it does not model the processor's state beyond the status input it is given.

Each rule owns one sticky violation bit. A bit is set in the cycle after the offending edge is sampled and stays set until the synchronous clear input is pulsed. A combined error output reports that any bit is set. The reset setup window is stated in microseconds and converted to bus clocks from a clock-frequency parameter. Every counter saturates and never wraps.

Top module: `pwr_seq_monitor`

## Requirements
- R1: When `sys_rst_n` rises, the four controls must have been sampled all high for at least SETUP_US*CLK_MHZ consecutive cycles before the edge, and also in the edge cycle itself. Otherwise `viol[0]` is set.
- R2: The counter for the reset setup window saturates at its limit. Holding the controls high for any length of time beyond the limit never causes a `viol[0]` on the next reset release.
- R3: After `sleep_n` rises, `stopclk_n` may rise only WAKE_GAP_CLKS or more cycles later. If it rises k cycles after the sleep release, with k < WAKE_GAP_CLKS, `viol[1]` is set. A release of both lines in the same cycle (k = 0) also counts.
- R4: A rise of `stopclk_n` with no sleep release pending since the previous stop-clock rise leaves `viol[1]` clear.
- R5: A fall of `sleep_n` is legal only in a cycle where `stopclk_n` is low and `grant_reached` is high. Any other fall sets `viol[2]`.
- R6: After `ack_resp` is sampled high, `grant_reached` must be sampled high in the same cycle or within the next ENTRY_CLKS cycles. Otherwise `viol[3]` is set in the cycle after the ENTRY_CLKS-th cycle.
- R7: Each `viol` bit is sticky and holds until `clr` is sampled high. `err` is high exactly when any `viol` bit is set. Both outputs are registered and reflect an event one cycle after it is sampled.
- R8: Sampling `clr` high clears every bit. A violation detected in the same cycle as `clr` is still recorded.
- R9: While `rst_n` is low, and after it is released, `viol` is 0 and `err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset of the monitor |
| clr | input | 1 | Synchronous clear of all sticky violation bits |
| stopclk_n | input | 1 | Observed stop-clock request, active low |
| sleep_n | input | 1 | Observed sleep request, active low |
| dsleep_n | input | 1 | Observed deep-sleep request, active low |
| dpwr_n | input | 1 | Observed deep-power-stop request, active low |
| sys_rst_n | input | 1 | Observed system reset, active low |
| ack_resp | input | 1 | Strobe marking the acknowledge response phase |
| grant_reached | input | 1 | High once the package has entered stop-grant |
| viol | output | 4 | Sticky bits: [0] reset setup, [1] wake gap, [2] sleep entry, [3] grant timeout |
| err | output | 1 | OR of all violation bits |

## Verification
The bench builds the monitor with CLK_MHZ=1 and SETUP_US=6, which gives a six-clock reset window, and with WAKE_GAP_CLKS=4 and ENTRY_CLKS=5. Because these windows are so short, each separation can be swept one clock at a time from zero to past its limit. Every timing rule is therefore checked on both sides of its boundary. With these values the quiet counter is only three bits wide, so a hold period long enough to wrap an unsaturated counter fits easily in a short run.

// File: rtl/psm_pkg.sv
package psm_pkg;
    localparam int RULE_CNT   = 4;
    localparam int RULE_SETUP = 0;
    localparam int RULE_WAKE  = 1;
    localparam int RULE_SLEEP = 2;
    localparam int RULE_GRANT = 3;

    typedef struct packed {
        logic stop_n;
        logic slp_n;
        logic dslp_n;
        logic dpwr_n;
    } ctl_pins_t;
endpackage

// File: rtl/psm_setup_chk.sv
module psm_setup_chk #(
    parameter int LIMIT = 48000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic all_high,
    input  logic rst_rise,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM_V = W'(LIMIT);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!all_high)
            st_d.cnt = '0;
        else if (st_q.cnt != LIM_V)
            st_d.cnt = st_q.cnt + 1'b1;
        // edge cycle must itself be quiet and preceded by LIMIT quiet samples
        hit = rst_rise && (!all_high || (st_q.cnt != LIM_V));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_sat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == LIM_V && all_high) |=> st_q.cnt == LIM_V);
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIM_V);
endmodule

// File: rtl/psm_gap_chk.sv
module psm_gap_chk #(
    parameter int GAP = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slp_rise,
    input  logic stop_rise,
    output logic hit
);
    localparam int W = $clog2(GAP + 1);
    localparam logic [W-1:0] GAP_V = W'(GAP);

    typedef struct packed {
        logic         armed;
        logic [W-1:0] since;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.since != GAP_V)
            st_d.since = st_q.since + 1'b1;
        if (slp_rise) begin
            st_d.since = W'(1);
            st_d.armed = 1'b1;
        end
        if (stop_rise)
            st_d.armed = 1'b0;
        hit = stop_rise && (slp_rise || (st_q.armed && (st_q.since < GAP_V)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{armed: 1'b0, since: GAP_V};
        else        st_q <= st_d;
    end

    p_since_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.since <= GAP_V);
    p_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_rise |=> !st_q.armed);
endmodule

// File: rtl/psm_grant_chk.sv
module psm_grant_chk #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    input  logic entered,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST_V = W'(LIMIT - 1);
    localparam logic [W-1:0] LIM_V  = W'(LIMIT);

    typedef struct packed {
        logic         pend;
        logic [W-1:0] wait_cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (st_q.pend) begin
            if (entered) begin
                st_d.pend = 1'b0;
            end else begin
                st_d.wait_cnt = st_q.wait_cnt + 1'b1;
                if (st_q.wait_cnt == LAST_V) begin
                    hit       = 1'b1;
                    st_d.pend = 1'b0;
                end
            end
        end
        if (ack) begin
            st_d.pend     = !entered;
            st_d.wait_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_wait_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> st_q.wait_cnt < LIM_V);
    p_entered_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (entered && !ack) |=> !st_q.pend);
endmodule

// File: rtl/pwr_seq_monitor.sv
module pwr_seq_monitor #(
    parameter int CLK_MHZ       = 100,
    parameter int SETUP_US      = 480,
    parameter int WAKE_GAP_CLKS = 10,
    parameter int ENTRY_CLKS    = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       stopclk_n,
    input  logic       sleep_n,
    input  logic       dsleep_n,
    input  logic       dpwr_n,
    input  logic       sys_rst_n,
    input  logic       ack_resp,
    input  logic       grant_reached,
    output logic [3:0] viol,
    output logic       err
);
    import psm_pkg::*;

    localparam int SETUP_CLKS = SETUP_US * CLK_MHZ;

    typedef struct packed {
        logic                stop_prev;
        logic                slp_prev;
        logic                rst_prev;
        logic [RULE_CNT-1:0] viol;
        logic                err;
    } st_t;

    localparam st_t ST_RST = '{stop_prev: 1'b1, slp_prev: 1'b1, rst_prev: 1'b1,
                               viol: '0, err: 1'b0};

    st_t                 st_d, st_q;
    ctl_pins_t           pins;
    logic                all_high, slp_rise, slp_fall, stop_rise, rst_rise, in_grant;
    logic [RULE_CNT-1:0] hit;

    always_comb begin
        pins      = '{stop_n: stopclk_n, slp_n: sleep_n, dslp_n: dsleep_n, dpwr_n: dpwr_n};
        all_high  = &pins;
        slp_rise  = sleep_n & ~st_q.slp_prev;
        slp_fall  = ~sleep_n & st_q.slp_prev;
        stop_rise = stopclk_n & ~st_q.stop_prev;
        rst_rise  = sys_rst_n & ~st_q.rst_prev;
        in_grant  = ~stopclk_n & grant_reached;
    end

    psm_setup_chk #(.LIMIT(SETUP_CLKS)) u_setup (
        .clk(clk), .rst_n(rst_n), .all_high(all_high), .rst_rise(rst_rise),
        .hit(hit[RULE_SETUP])
    );

    psm_gap_chk #(.GAP(WAKE_GAP_CLKS)) u_gap (
        .clk(clk), .rst_n(rst_n), .slp_rise(slp_rise), .stop_rise(stop_rise),
        .hit(hit[RULE_WAKE])
    );

    assign hit[RULE_SLEEP] = slp_fall & ~in_grant;

    psm_grant_chk #(.LIMIT(ENTRY_CLKS)) u_grant (
        .clk(clk), .rst_n(rst_n), .ack(ack_resp), .entered(grant_reached),
        .hit(hit[RULE_GRANT])
    );

    always_comb begin
        st_d           = st_q;
        st_d.stop_prev = stopclk_n;
        st_d.slp_prev  = sleep_n;
        st_d.rst_prev  = sys_rst_n;
        st_d.viol      = (clr ? '0 : st_q.viol) | hit;
        st_d.err       = |st_d.viol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign viol = st_q.viol;
    assign err  = st_q.err;

    for (genvar gi = 0; gi < RULE_CNT; gi++) begin : g_rule
        p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.viol[gi] && !clr) |=> st_q.viol[gi]);
        p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !hit[gi]) |=> !st_q.viol[gi]);
        p_record_r8: assert property (@(posedge clk) disable iff (!rst_n)
            hit[gi] |=> st_q.viol[gi]);
    end

    p_setup_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_rise && !all_high) |=> viol[RULE_SETUP]);
    p_sleep_off_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slp_fall && stopclk_n) |=> viol[RULE_SLEEP]);
    p_err_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err == (viol != '0));
endmodule

// File: tb/tb_pwr_seq_monitor.sv
module tb_pwr_seq_monitor;
    localparam int CLK_MHZ = 1;
    localparam int SETUP_US = 6;
    localparam int GAP = 4;
    localparam int ENTRY = 5;
    localparam int SETUP = CLK_MHZ * SETUP_US;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic [3:0] pv = 4'hF;  // [3] stop, [2] sleep, [1] deep sleep, [0] deep power stop
    logic       sys_rst_n = 1'b1;
    logic       ack = 1'b0;
    logic       sg = 1'b0;
    logic [3:0] viol;
    logic       err;
    int         vectors = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    pwr_seq_monitor #(.CLK_MHZ(CLK_MHZ), .SETUP_US(SETUP_US),
                      .WAKE_GAP_CLKS(GAP), .ENTRY_CLKS(ENTRY)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .stopclk_n(pv[3]), .sleep_n(pv[2]), .dsleep_n(pv[1]), .dpwr_n(pv[0]),
        .sys_rst_n(sys_rst_n), .ack_resp(ack), .grant_reached(sg),
        .viol(viol), .err(err)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_clr();
        clr = 1'b1;
        tick();
        clr = 1'b0;
    endtask

    task automatic ckb(string req, int idx, logic exp);
        vectors++;
        if (viol[idx] !== exp) begin
            fails++;
            $display("FAIL %s: viol[%0d] got %0b expected %0b", req, idx, viol[idx], exp);
        end
    endtask

    task automatic ckv(string req, logic [3:0] exp);
        vectors++;
        if (viol !== exp || err !== (exp != 4'b0)) begin
            fails++;
            $display("FAIL %s: viol/err got %b/%0b expected %b/%0b", req, viol, err, exp, exp != 4'b0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (2) tick();
        ckv("R9 in reset", 4'b0000);
        rst_n = 1'b1;
        tick();
        ckv("R9 after reset", 4'b0000);

        // R1: sweep quiet time before reset release (deep lines toggled)
        for (int h = 0; h <= SETUP + 3; h++) begin
            sys_rst_n = 1'b0;
            pv[1:0] = 2'b00;
            tick();
            pv[1:0] = 2'b11;
            repeat (h) tick();
            sys_rst_n = 1'b1;
            tick();
            ckb("R1 sweep", 0, h < SETUP);
            do_clr();
        end

        // R1: each control line alone, one clock either side of the limit
        sg = 1'b1;
        for (int p = 0; p < 4; p++) begin
            for (int h = SETUP - 1; h <= SETUP; h++) begin
                sys_rst_n = 1'b0;
                repeat (SETUP + 2) tick();
                pv[p] = 1'b0;
                tick();
                pv[p] = 1'b1;
                repeat (h) tick();
                sys_rst_n = 1'b1;
                tick();
                ckb("R1 per line", 0, h < SETUP);
                do_clr();
            end
        end

        // R1: line low in the release cycle itself
        sys_rst_n = 1'b0;
        repeat (SETUP + 2) tick();
        pv[0] = 1'b0;
        sys_rst_n = 1'b1;
        tick();
        pv[0] = 1'b1;
        ckb("R1 low at edge", 0, 1'b1);
        do_clr();

        // R2: hold long enough to wrap an unsaturated counter
        sys_rst_n = 1'b0;
        repeat ((2 ** $clog2(SETUP + 1)) * 5 + 1) tick();
        sys_rst_n = 1'b1;
        tick();
        ckb("R2 saturation", 0, 1'b0);

        // R3: sweep gap between sleep release and stop-clock release
        for (int k = 0; k <= GAP + 2; k++) begin
            pv[3] = 1'b0;
            tick();
            pv[2] = 1'b0;
            tick();
            pv[2] = 1'b1;
            repeat (k) tick();
            pv[3] = 1'b1;
            tick();
            ckb("R3 gap sweep", 1, k < GAP);
            ckb("R3 legal sleep", 2, 1'b0);
            do_clr();
        end

        // R4: stop-clock cycle without any sleep release
        pv[3] = 1'b0;
        tick();
        pv[3] = 1'b1;
        tick();
        ckv("R4 no pending sleep exit", 4'b0000);

        // R5: sleep fall against every stop/grant combination
        for (int s = 0; s < 2; s++) begin
            for (int g = 0; g < 2; g++) begin
                pv[3] = s[0];
                sg = g[0];
                tick();
                pv[2] = 1'b0;
                tick();
                ckb("R5 sleep entry", 2, !(s == 0 && g == 1));
                pv[2] = 1'b1;
                repeat (GAP + 1) tick();
                pv[3] = 1'b1;
                tick();
                do_clr();
            end
        end

        // R6: sweep delay from acknowledge to grant
        sg = 1'b0;
        for (int k = 0; k <= ENTRY + 3; k++) begin
            ack = 1'b1;
            if (k == 0) sg = 1'b1;
            tick();
            ack = 1'b0;
            if (k > 0) begin
                repeat (k - 1) tick();
                sg = 1'b1;
                tick();
            end
            ckb("R6 entry sweep", 3, k > ENTRY);
            sg = 1'b0;
            tick();
            do_clr();
        end

        // R6: exact cycle of the timeout report
        ack = 1'b1;
        tick();
        ack = 1'b0;
        repeat (ENTRY - 1) tick();
        ckb("R6 before limit", 3, 1'b0);
        tick();
        ckb("R6 at limit", 3, 1'b1);
        do_clr();

        // R7: stickiness and combined error
        pv[2] = 1'b0;
        tick();
        ckv("R7 set", 4'b0100);
        pv[2] = 1'b1;
        repeat (GAP + 6) tick();
        ckv("R7 held", 4'b0100);
        ack = 1'b1;
        tick();
        ack = 1'b0;
        repeat (ENTRY) tick();
        ckv("R7 two rules", 4'b1100);

        // R8: clear, then clear racing a new violation
        do_clr();
        ckv("R8 cleared", 4'b0000);
        ack = 1'b1;
        tick();
        ack = 1'b0;
        repeat (ENTRY) tick();
        ckv("R8 prepare", 4'b1000);
        clr = 1'b1;
        pv[2] = 1'b0;
        tick();
        clr = 1'b0;
        pv[2] = 1'b1;
        ckv("R8 same-cycle event kept", 4'b0100);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule